// File: doc/BRIEF.md
# Acquisition Card Control and Status Register Bank

This block is the 16-bit register bank of a data-acquisition function card. It sits on a simple synchronous bus with a read strobe, a write strobe, a word address and a 16-bit data word. Read data is combinational and depends on the address while the read strobe is high. The bank holds three words. The first is a fixed identification word. The second is a version word made of two revision bytes. The third is a control and status word.

The control and status word carries four things: a master/slave mode bit that software may change only while the main sequencer is idle, a reserved bit, a sticky end-of-acquisition flag, and a live copy of the sequencer state code. The sequencer, the converter data path and the interrupt routing sit outside the block. Their events arrive as single-cycle strobes. The block raises a one-cycle interrupt-request pulse when the end flag rises, and external interrupt logic consumes it.

Top module: `acq_card_regs`

## Requirements
- R1: A read of word address 0 returns the identification parameter (default 16'h3424) on every read.
- R2: A read of word address 1 returns the logic revision byte in bits 15:8 and the board revision byte in bits 7:0. In each byte the high nibble is the major revision and the low nibble is the minor revision. Defaults are 8'h12 and 8'h21, so the word reads 16'h1221.
- R3: The mode bit is bit 15 of word address 2 (1 = master, 0 = slave) and resets to 0. A write to address 2 while the sequencer state is 3'b000 (idle) loads wdata[15] into it, and the new value is visible from the next cycle.
- R4: A write to address 2 while the sequencer state is not 3'b000 leaves the mode bit unchanged.
- R5: Bit 14 of address 2 always reads 0. Writes to addresses 0 and 1, and to bits 14:0 of address 2, change no value that can be read.
- R6: The end flag (bit 13 of address 2) resets to 0. It becomes 1 in the cycle after a normal-completion strobe or a skip strobe, and it stays 1 until it is cleared.
- R7: An error strobe or a software-reset strobe never sets the end flag. If either one arrives in the same cycle as a completion or skip strobe, that strobe is suppressed too.
- R8: An arm command or a clear command clears the end flag in the next cycle. A clear in the same cycle as a set event wins.
- R9: Bits 12:10 of address 2 show the current sequencer state input with no delay. For example, 3'b000 is idle and 3'b001 is the synthesizer-update state.
- R10: A read of any address other than 0, 1 or 2 returns 0, and rdata is 0 whenever the read strobe is low.
- R11: The interrupt request is high for exactly the one cycle in which the end flag changes from 0 to 1. A set event while the flag is already 1 raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| seq_state | input | 3 | Main sequencer state code |
| ev_done | input | 1 | Acquisition completed normally |
| ev_skip | input | 1 | Skip operation performed |
| ev_error | input | 1 | Acquisition ended with an error |
| ev_swreset | input | 1 | Acquisition ended by software reset |
| cmd_arm | input | 1 | Arm command |
| cmd_clear | input | 1 | Clear command |
| master_mode | output | 1 | Current mode bit (1 = master) |
| end_flag | output | 1 | Sticky end-of-acquisition flag |
| end_irq | output | 1 | One-cycle interrupt request on end-flag rise |

## Verification
The mode bit is written with both values while the sequencer is idle and again while it is busy. This separates a write that is gated by the state from a write that is always taken or never taken. The end flag is driven by each set strobe alone, by each suppressing strobe alone, by a set strobe together with a suppressing strobe, and by a set strobe together with a clear. These cases separate correct priority from a plain OR of the events. Reads of the constant words, the reserved bit, several state codes and unmapped addresses, taken after writes aimed at read-only fields, show that those writes changed nothing that can be read.

// File: rtl/acq_regs_pkg.sv
package acq_regs_pkg;

  localparam int DATA_W = 16;
  localparam int STATE_W = 3;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [STATE_W-1:0] state_t;

  localparam state_t SEQ_IDLE = 3'b000;

  // Bit positions inside the control/status word
  localparam int CTRL_MODE_BIT = 15;
  localparam int CTRL_RSVD_BIT = 14;
  localparam int CTRL_END_BIT  = 13;
  localparam int CTRL_ST_LSB   = 10;

  function automatic word_t pack_version(input logic [7:0] logic_rev,
                                         input logic [7:0] board_rev);
    return {logic_rev, board_rev};
  endfunction

  function automatic word_t pack_ctrl(input logic mode, input logic flag,
                                      input state_t st);
    word_t w;
    w = '0;
    w[CTRL_MODE_BIT] = mode;
    w[CTRL_RSVD_BIT] = 1'b0;
    w[CTRL_END_BIT]  = flag;
    w[CTRL_ST_LSB +: STATE_W] = st;
    return w;
  endfunction

  function automatic logic mode_from_word(input word_t w);
    return w[CTRL_MODE_BIT];
  endfunction

  // A set is valid only without an abnormal termination in the same cycle
  function automatic logic end_set_ok(input logic done, input logic skip,
                                      input logic err, input logic swrst);
    return (done | skip) & ~err & ~swrst;
  endfunction

endpackage

// File: rtl/acq_mode_reg.sv
module acq_mode_reg
  import acq_regs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_hit,
  input  word_t  wdata,
  input  state_t seq_state,
  output logic   load_ok,
  output logic   mode_q
);

  assign load_ok = wr_hit && (seq_state == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (load_ok) begin
      mode_q <= mode_from_word(wdata);
    end
  end

endmodule

// File: rtl/acq_end_flag.sv
module acq_end_flag
  import acq_regs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_done,
  input  logic ev_skip,
  input  logic ev_error,
  input  logic ev_swreset,
  input  logic cmd_arm,
  input  logic cmd_clear,
  output logic set_ev,
  output logic clr_ev,
  output logic flag_q,
  output logic irq_q
);

  logic rise;

  assign set_ev = end_set_ok(ev_done, ev_skip, ev_error, ev_swreset);
  assign clr_ev = cmd_arm | cmd_clear;
  assign rise   = set_ev & ~clr_ev & ~flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= rise;
      if (clr_ev) begin
        flag_q <= 1'b0;
      end else if (set_ev) begin
        flag_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/acq_read_mux.sv
module acq_read_mux
  import acq_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int IDX_ID = 0,
  parameter int IDX_VER = 1,
  parameter int IDX_CTRL = 2
) (
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             id_word,
  input  word_t             ver_word,
  input  word_t             ctrl_word,
  output word_t             rdata
);

  localparam int NREG = 3;

  word_t         regs [NREG];
  int            idxs [NREG];
  logic [NREG-1:0] hit;

  assign regs[0] = id_word;
  assign regs[1] = ver_word;
  assign regs[2] = ctrl_word;
  assign idxs[0] = IDX_ID;
  assign idxs[1] = IDX_VER;
  assign idxs[2] = IDX_CTRL;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = rd && (addr == idxs[g][ADDR_W-1:0]);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rdata = rdata | regs[i];
    end
  end

endmodule

// File: rtl/acq_card_regs.sv
module acq_card_regs
  import acq_regs_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter logic [15:0] ID_VALUE  = 16'h3424,
  parameter logic [7:0]  LOGIC_REV = 8'h12,
  parameter logic [7:0]  BOARD_REV = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [2:0]        seq_state,
  input  logic              ev_done,
  input  logic              ev_skip,
  input  logic              ev_error,
  input  logic              ev_swreset,
  input  logic              cmd_arm,
  input  logic              cmd_clear,
  output logic              master_mode,
  output logic              end_flag,
  output logic              end_irq
);

  localparam int IDX_ID   = 0;
  localparam int IDX_VER  = 1;
  localparam int IDX_CTRL = 2;

  // Named internal events, visible to the checker
  logic  ctrl_wr_hit;
  logic  mode_load;
  logic  end_set;
  logic  end_clr;
  word_t ctrl_word;
  word_t ver_word;

  assign ctrl_wr_hit = bus_wr && (bus_addr == ADDR_W'(IDX_CTRL));
  assign ver_word    = pack_version(LOGIC_REV, BOARD_REV);
  assign ctrl_word   = pack_ctrl(master_mode, end_flag, seq_state);

  acq_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (ctrl_wr_hit),
    .wdata     (bus_wdata),
    .seq_state (seq_state),
    .load_ok   (mode_load),
    .mode_q    (master_mode)
  );

  acq_end_flag u_end (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_done    (ev_done),
    .ev_skip    (ev_skip),
    .ev_error   (ev_error),
    .ev_swreset (ev_swreset),
    .cmd_arm    (cmd_arm),
    .cmd_clear  (cmd_clear),
    .set_ev     (end_set),
    .clr_ev     (end_clr),
    .flag_q     (end_flag),
    .irq_q      (end_irq)
  );

  acq_read_mux #(
    .ADDR_W   (ADDR_W),
    .IDX_ID   (IDX_ID),
    .IDX_VER  (IDX_VER),
    .IDX_CTRL (IDX_CTRL)
  ) u_rmux (
    .rd        (bus_rd),
    .addr      (bus_addr),
    .id_word   (ID_VALUE),
    .ver_word  (ver_word),
    .ctrl_word (ctrl_word),
    .rdata     (bus_rdata)
  );

endmodule

// File: rtl/acq_card_regs_chk.sv
module acq_card_regs_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic [2:0]        seq_state,
  input logic              ev_done,
  input logic              ev_skip,
  input logic              ev_error,
  input logic              ev_swreset,
  input logic              cmd_arm,
  input logic              cmd_clear,
  input logic              master_mode,
  input logic              end_flag,
  input logic              end_irq,
  input logic              mode_load,
  input logic              end_set,
  input logic              end_clr
);

  logic wr_ctrl;
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(2));

  a_r3_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && seq_state == 3'b000) |=> (master_mode == $past(bus_wdata[15])));

  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctrl && seq_state == 3'b000) |=> $stable(master_mode));

  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_done || ev_skip) && !ev_error && !ev_swreset && !cmd_arm && !cmd_clear)
      |=> end_flag);

  a_r7_no_bad_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> $past((ev_done || ev_skip) && !ev_error && !ev_swreset));

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_arm || cmd_clear) |=> !end_flag);

  a_r11_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |-> (end_flag && !$past(end_flag)));

  a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |=> !end_irq);

  a_r3_load_is_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |-> (wr_ctrl && seq_state == 3'b000));

  a_r7_set_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    end_set |-> !(ev_error || ev_swreset));

  a_r8_clr_source: assert property (@(posedge clk) disable iff (!rst_n)
    end_clr |-> (cmd_arm || cmd_clear));

  always_comb begin
    if (rst_n && bus_rd && bus_addr == ADDR_W'(2)) begin
      a_r9_state_mirror: assert (bus_rdata[12:10] == seq_state && !bus_rdata[14]);
    end
    if (rst_n && (!bus_rd || bus_addr > ADDR_W'(2))) begin
      a_r10_unmapped_zero: assert (bus_rdata == 16'h0000);
    end
  end

endmodule

bind acq_card_regs acq_card_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .seq_state   (seq_state),
  .ev_done     (ev_done),
  .ev_skip     (ev_skip),
  .ev_error    (ev_error),
  .ev_swreset  (ev_swreset),
  .cmd_arm     (cmd_arm),
  .cmd_clear   (cmd_clear),
  .master_mode (master_mode),
  .end_flag    (end_flag),
  .end_irq     (end_irq),
  .mode_load   (mode_load),
  .end_set     (end_set),
  .end_clr     (end_clr)
);

// File: tb/sim_acq_card_regs.sv
module sim_acq_card_regs;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [15:0]       bus_wdata = '0;
  logic [15:0]       bus_rdata;
  logic [2:0]        seq_state = 3'b000;
  logic              ev_done = 1'b0, ev_skip = 1'b0, ev_error = 1'b0;
  logic              ev_swreset = 1'b0, cmd_arm = 1'b0, cmd_clear = 1'b0;
  logic              master_mode, end_flag, end_irq;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_card_regs #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_state(seq_state), .ev_done(ev_done), .ev_skip(ev_skip),
    .ev_error(ev_error), .ev_swreset(ev_swreset), .cmd_arm(cmd_arm),
    .cmd_clear(cmd_clear), .master_mode(master_mode), .end_flag(end_flag),
    .end_irq(end_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Drive one cycle of strobes; returns at the negedge after the capturing edge
  task automatic strobe(input logic d, input logic s, input logic e,
                        input logic sr, input logic a, input logic c);
    @(negedge clk);
    ev_done = d; ev_skip = s; ev_error = e; ev_swreset = sr;
    cmd_arm = a; cmd_clear = c;
    @(negedge clk);
    {ev_done, ev_skip, ev_error, ev_swreset, cmd_arm, cmd_clear} = '0;
  endtask

  function automatic logic [15:0] ctrl_exp(input logic m, input logic f, input logic [2:0] st);
    return {m, 1'b0, f, st, 10'd0};
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    rd(4'd2, d);
    chk("R3 reset ctrl", d, 16'h0000);
    chk("R11 reset irq", {15'd0, end_irq}, 16'h0000);
  endtask

  task automatic t_constants();
    logic [15:0] d;
    rd(4'd0, d); chk("R1 id", d, 16'h3424);
    rd(4'd1, d); chk("R2 version", d, 16'h1221);
    rd(4'd0, d); chk("R1 id repeat", d, 16'h3424);
  endtask

  task automatic t_mode_idle();
    logic [15:0] d;
    seq_state = 3'b000;
    wr(4'd2, 16'h8000);
    chk("R3 master set", {15'd0, master_mode}, 16'h0001);
    wr(4'd2, 16'h0000);
    rd(4'd2, d);
    chk("R3 master cleared", d, ctrl_exp(1'b0, 1'b0, 3'b000));
    wr(4'd2, 16'h8000);
  endtask

  task automatic t_mode_busy();
    logic [15:0] d;
    seq_state = 3'b001;
    wr(4'd2, 16'h0000);
    rd(4'd2, d);
    chk("R4 busy write ignored", d, ctrl_exp(1'b1, 1'b0, 3'b001));
    seq_state = 3'b000;
    wr(4'd2, 16'h0000);
    seq_state = 3'b110;
    wr(4'd2, 16'h8000);
    chk("R4 busy set ignored", {15'd0, master_mode}, 16'h0000);
    seq_state = 3'b000;
  endtask

  task automatic t_ro_writes();
    logic [15:0] d;
    wr(4'd0, 16'hFFFF);
    wr(4'd1, 16'h0000);
    wr(4'd2, 16'h7FFF);
    rd(4'd0, d); chk("R5 id after write", d, 16'h3424);
    rd(4'd1, d); chk("R5 version after write", d, 16'h1221);
    rd(4'd2, d); chk("R5 ctrl low bits", d, ctrl_exp(1'b0, 1'b0, 3'b000));
  endtask

  task automatic t_end_done();
    logic [15:0] d;
    strobe(1, 0, 0, 0, 0, 0);
    chk("R6 done sets flag", {15'd0, end_flag}, 16'h0001);
    chk("R11 irq pulse", {15'd0, end_irq}, 16'h0001);
    @(negedge clk);
    chk("R11 irq one cycle", {15'd0, end_irq}, 16'h0000);
    rd(4'd2, d);
    chk("R6 flag sticky", d, ctrl_exp(1'b0, 1'b1, 3'b000));
    strobe(0, 1, 0, 0, 0, 0);
    chk("R11 no irq when set", {15'd0, end_irq}, 16'h0000);
    strobe(0, 0, 0, 0, 1, 0);
    chk("R8 arm clears", {15'd0, end_flag}, 16'h0000);
  endtask

  task automatic t_end_skip();
    strobe(0, 1, 0, 0, 0, 0);
    chk("R6 skip sets flag", {15'd0, end_flag}, 16'h0001);
    strobe(0, 0, 0, 0, 0, 1);
    chk("R8 clear clears", {15'd0, end_flag}, 16'h0000);
  endtask

  task automatic t_abnormal();
    strobe(0, 0, 1, 0, 0, 0);
    chk("R7 error alone", {15'd0, end_flag}, 16'h0000);
    strobe(0, 0, 0, 1, 0, 0);
    chk("R7 swreset alone", {15'd0, end_flag}, 16'h0000);
    strobe(1, 0, 1, 0, 0, 0);
    chk("R7 done with error", {15'd0, end_flag}, 16'h0000);
    strobe(0, 1, 0, 1, 0, 0);
    chk("R7 skip with swreset", {15'd0, end_flag}, 16'h0000);
    chk("R11 no irq on abnormal", {15'd0, end_irq}, 16'h0000);
  endtask

  task automatic t_priority();
    strobe(1, 0, 0, 0, 0, 1);
    chk("R8 clear beats done", {15'd0, end_flag}, 16'h0000);
    chk("R11 no irq on clear win", {15'd0, end_irq}, 16'h0000);
    strobe(0, 1, 0, 0, 1, 0);
    chk("R8 arm beats skip", {15'd0, end_flag}, 16'h0000);
  endtask

  task automatic t_state_mirror();
    logic [15:0] d;
    for (int s = 0; s < 8; s++) begin
      seq_state = 3'(s);
      rd(4'd2, d);
      chk("R9 state mirror", d, ctrl_exp(1'b0, 1'b0, 3'(s)));
    end
    seq_state = 3'b000;
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    rd(4'd3, d);  chk("R10 addr 3", d, 16'h0000);
    rd(4'd15, d); chk("R10 addr 15", d, 16'h0000);
    @(negedge clk);
    bus_addr = 4'd0; bus_rd = 1'b0;
    #1 chk("R10 no strobe", bus_rdata, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_constants();
    t_mode_idle();
    t_mode_busy();
    t_ro_writes();
    t_end_done();
    t_end_skip();
    t_abnormal();
    t_priority();
    t_state_mirror();
    t_unmapped();
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule